// File: doc/BRIEF.md
# Network Controller Interrupt Cause and Mask Unit

This unit collects single-cycle event pulses from the receive and transmit engines of a network controller. It records each event as a sticky cause bit and drives one level-sensitive interrupt line towards the host. Software reaches the unit through a small register port of 32-bit words. Through that port it can read the causes, read them with a conditional clear, clear them by writing ones, inject causes, set or clear enable bits in a mask, load an auto-mask pattern and program a throttle interval.

The top bit of the cause word is the line-asserted flag. The 31 bits below it are individual causes. An event is either raised at once or deferred by a one-shot throttle timer. The timer counts in units of `UNIT_CYCLES` clocks, which stand for 256 ns. Events in a parameterised immediate set, such as receive overrun, bypass the throttle. The line is only ever high while at least one enabled cause is pending.

Register offsets on `reg_addr`: 0 cause, 1 cause-inject, 2 mask-set, 3 mask-clear, 4 auto-mask pattern, 5 throttle interval, 6 control (bit 0 = auto-mask enable). A read of offset 2 or 3 returns the mask. A read of offset 1 returns zero. Every access takes effect at the clock edge that samples `reg_valid`. Read data is combinational from the current state.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset the causes, the flag, the mask, the auto-mask pattern, the interval and the control bit all read zero, and `irq_o` is low.
- R2: A pulse on `evt_pulse[i]` sets cause bit i. With a zero interval and bit i enabled in the mask, `irq_o` rises at that same edge, and a cause read returns bit 31 set together with bit i.
- R3: A cause read (offset 0) returns {flag, causes} and then clears bits 30:0, but only if the flag was set or the mask was zero; otherwise the causes are kept.
- R4: On a cause read with control bit 0 set and the flag set, the mask becomes mask AND NOT pattern; with the flag clear the mask is unchanged.
- R5: A write to offset 0 clears every cause bit written as one. If control bit 0 is set, it first applies mask AND NOT pattern.
- R6: A write to offset 2 ORs the data into the mask; a write to offset 3 clears the mask bits written as one.
- R7: A write to offset 1 posts bits 30:0 as events with the same rules as `evt_pulse`, including the immediate rule.
- R8: Posting a non-immediate event whose cause bit is already set has no effect on the line or the timer. An event in the immediate set (default bit 6) raises the line at once, regardless of the interval and even when its bit is already set.
- R9: With interval v > 0, an enabled event with the line low and the timer idle starts a one-shot timer. The line rises v*UNIT_CYCLES cycles after the starting edge. Further events while the timer runs do not restart it.
- R10: Whenever cause AND mask becomes zero, the flag and `irq_o` fall at that edge and a running timer is cancelled, so that a later start counts a full interval.
- R11: A cause that was pending while masked fires once it is enabled through a mask-set write: at once with a zero interval, after a full interval otherwise.
- R12: The mask, the pattern, the interval (low `IV_W` bits) and the control bit read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe, one access per cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 31 | One-cycle event pulses, one per cause bit |
| irq_o | output | 1 | Level interrupt line to the host |

## Verification
The bench builds the unit with `UNIT_CYCLES` = 4 and `IV_W` = 8. An interval of 2 then spans only eight cycles, so the bench can check the throttle edge exactly: the line stays low one cycle before the expected edge and is high on it. It can also check a mid-interval repost, an immediate override and a cancel-then-restart. All 31 cause bits are swept one by one through mask-set, event, read-to-clear and mask-clear. This exposes any bit that is mis-wired between the event, mask and cause paths.

// File: rtl/nic_irq_pkg.sv
`timescale 1ns/1ps
package nic_irq_pkg;

   localparam int IRQ_ADDR_W = 3;

   typedef enum logic [IRQ_ADDR_W-1:0] {
      ADR_CAUSE = 3'd0,
      ADR_CSET  = 3'd1,
      ADR_MSET  = 3'd2,
      ADR_MCLR  = 3'd3,
      ADR_AMASK = 3'd4,
      ADR_THR   = 3'd5,
      ADR_CTL   = 3'd6
   } irq_reg_e;

   typedef struct packed {
      logic rd_cause;
      logic wr_cause;
      logic wr_cset;
      logic wr_mset;
      logic wr_mclr;
      logic wr_amask;
      logic wr_thr;
      logic wr_ctl;
   } irq_strobe_t;

endpackage

// File: rtl/nic_irq_decode.sv
`timescale 1ns/1ps
module nic_irq_decode
   import nic_irq_pkg::*;
#(
   parameter int ADDR_W = IRQ_ADDR_W
) (
   input  logic              valid,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   output irq_strobe_t       stb
);

   always_comb begin
      stb = '0;
      if (valid) begin
         case (addr)
            ADR_CAUSE: begin
               stb.rd_cause = !write;
               stb.wr_cause = write;
            end
            ADR_CSET:  stb.wr_cset  = write;
            ADR_MSET:  stb.wr_mset  = write;
            ADR_MCLR:  stb.wr_mclr  = write;
            ADR_AMASK: stb.wr_amask = write;
            ADR_THR:   stb.wr_thr   = write;
            ADR_CTL:   stb.wr_ctl   = write;
            default:   stb = '0;
         endcase
      end
   end

endmodule

// File: rtl/nic_irq_throttle.sv
`timescale 1ns/1ps
module nic_irq_throttle #(
   parameter int IV_W        = 16,
   parameter int UNIT_CYCLES = 51,
   parameter bit ENABLE      = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IV_W-1:0] interval,
   input  logic            start,
   input  logic            cancel,
   output logic            running,
   output logic            expire
);

   localparam int UW    = $clog2(UNIT_CYCLES + 1);
   localparam int CNT_W = IV_W + UW;

   generate
      if (UNIT_CYCLES < 1) begin : g_bad_unit
         $error("nic_irq_throttle: UNIT_CYCLES must be at least 1");
      end

      if (ENABLE) begin : g_timer
         logic [CNT_W-1:0] cnt_q;
         logic             run_q;
         logic [CNT_W-1:0] load_val;

         assign load_val = CNT_W'(interval) * CNT_W'(UNIT_CYCLES);
         assign expire   = run_q && (cnt_q == CNT_W'(1));
         assign running  = run_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q <= 1'b0;
               cnt_q <= '0;
            end else if (cancel || expire) begin
               run_q <= 1'b0;
               cnt_q <= '0;
            end else if (start) begin
               run_q <= 1'b1;
               cnt_q <= load_val;
            end else if (run_q) begin
               cnt_q <= cnt_q - CNT_W'(1);
            end
         end
      end else begin : g_bypass
         logic unused_ins;
         assign unused_ins = ^{interval, start, cancel, clk, rst_n};
         assign running    = 1'b0;
         assign expire     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/nic_irq_ctrl.sv
`timescale 1ns/1ps
module nic_irq_ctrl
   import nic_irq_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = IRQ_ADDR_W,
   parameter int          IV_W        = 16,
   parameter int          UNIT_CYCLES = 51,
   parameter bit          THROTTLE_EN = 1'b1,
   parameter int unsigned IMM_BITS    = 32'h0000_0040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-2:0] evt_pulse,
   output logic              irq_o
);

   localparam int NCAUSE = DATA_W - 1;
   localparam logic [NCAUSE-1:0] IMM_SET = NCAUSE'(IMM_BITS);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("nic_irq_ctrl: DATA_W must be at least 2");
      end
      if (IV_W > DATA_W) begin : g_bad_iv
         $error("nic_irq_ctrl: IV_W must not exceed DATA_W");
      end
      if (ADDR_W != IRQ_ADDR_W) begin : g_bad_addr
         $error("nic_irq_ctrl: ADDR_W must match the register map");
      end
   endgenerate

   logic [NCAUSE-1:0] cause_q, mask_q, amask_q;
   logic [IV_W-1:0]   interval_q;
   logic              irq_q, ame_q;

   irq_strobe_t       stb;
   logic [NCAUSE-1:0] cause_a, mask_a, posted, taken, cause_n;
   logic              post_any, imm_hit, active, reval, thr_zero;
   logic              raise, start, cancel, irq_n;
   logic              tmr_running, tmr_expire;

   nic_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
      .valid (reg_valid),
      .write (reg_write),
      .addr  (reg_addr),
      .stb   (stb)
   );

   nic_irq_throttle #(
      .IV_W        (IV_W),
      .UNIT_CYCLES (UNIT_CYCLES),
      .ENABLE      (THROTTLE_EN)
   ) u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .interval (interval_q),
      .start    (start),
      .cancel   (cancel),
      .running  (tmr_running),
      .expire   (tmr_expire)
   );

   // Register access effects, applied before the event merge.
   always_comb begin
      cause_a = cause_q;
      mask_a  = mask_q;
      posted  = evt_pulse;
      if (stb.rd_cause) begin
         if (irq_q || (mask_q == '0)) cause_a = '0;
         if (ame_q && irq_q)          mask_a  = mask_q & ~amask_q;
      end
      if (stb.wr_cause) begin
         if (ame_q) mask_a = mask_q & ~amask_q;
         cause_a = cause_q & ~reg_wdata[NCAUSE-1:0];
      end
      if (stb.wr_cset) posted = posted | reg_wdata[NCAUSE-1:0];
      if (stb.wr_mset) mask_a = mask_q | reg_wdata[NCAUSE-1:0];
      if (stb.wr_mclr) mask_a = mask_q & ~reg_wdata[NCAUSE-1:0];
   end

   // Event posting, line evaluation and timer control.
   always_comb begin
      taken    = posted & (~cause_a | IMM_SET);
      post_any = |taken;
      imm_hit  = |(taken & IMM_SET);
      cause_n  = cause_a | posted;
      active   = |(cause_n & mask_a);
      reval    = stb.rd_cause | stb.wr_cause | stb.wr_mset | stb.wr_mclr;
      thr_zero = !THROTTLE_EN || (interval_q == '0);
      raise    = active && (imm_hit || tmr_expire || ((post_any || reval) && thr_zero));
      start    = active && !irq_q && !raise && (post_any || reval) && !tmr_running;
      cancel   = raise || !active;
      irq_n    = active && (irq_q || raise);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q    <= '0;
         mask_q     <= '0;
         amask_q    <= '0;
         interval_q <= '0;
         ame_q      <= 1'b0;
         irq_q      <= 1'b0;
      end else begin
         cause_q <= cause_n;
         mask_q  <= mask_a;
         irq_q   <= irq_n;
         if (stb.wr_amask) amask_q    <= reg_wdata[NCAUSE-1:0];
         if (stb.wr_thr)   interval_q <= reg_wdata[IV_W-1:0];
         if (stb.wr_ctl)   ame_q      <= reg_wdata[0];
      end
   end

   always_comb begin
      case (reg_addr)
         ADR_CAUSE:          reg_rdata = {irq_q, cause_q};
         ADR_MSET, ADR_MCLR: reg_rdata = {1'b0, mask_q};
         ADR_AMASK:          reg_rdata = {1'b0, amask_q};
         ADR_THR:            reg_rdata = DATA_W'(interval_q);
         ADR_CTL:            reg_rdata = DATA_W'(ame_q);
         default:            reg_rdata = '0;
      endcase
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/nic_irq_chk.sv
`timescale 1ns/1ps
module nic_irq_chk
   import nic_irq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = IRQ_ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_valid,
   input logic              reg_write,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-2:0] evt_pulse,
   input logic              irq_o,
   input logic [DATA_W-2:0] cause_q,
   input logic [DATA_W-2:0] mask_q
);

   localparam int NC = DATA_W - 1;

   p_line_needs_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((cause_q & mask_q) != '0));

   p_event_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pulse != '0) |=> ((cause_q & $past(evt_pulse)) == $past(evt_pulse)));

   p_mask_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_write && reg_addr == ADR_MSET)
      |=> ((mask_q & $past(reg_wdata[NC-1:0])) == $past(reg_wdata[NC-1:0])));

   p_mask_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_write && reg_addr == ADR_MCLR)
      |=> ((mask_q & $past(reg_wdata[NC-1:0])) == '0));

   p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && reg_write && reg_addr == ADR_CAUSE && evt_pulse == '0)
      |=> ((cause_q & $past(reg_wdata[NC-1:0])) == '0));

   p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_valid && !reg_write && reg_addr == ADR_CAUSE && irq_o && evt_pulse == '0)
      |=> (cause_q == '0));

endmodule

bind nic_irq_ctrl nic_irq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_valid (reg_valid),
   .reg_write (reg_write),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .evt_pulse (evt_pulse),
   .irq_o     (irq_o),
   .cause_q   (cause_q),
   .mask_q    (mask_q)
);

// File: tb/nic_irq_ctrl_test.sv
`timescale 1ns/1ps
module nic_irq_ctrl_test;
   import nic_irq_pkg::*;

   localparam int DW   = 32;
   localparam int UNIT = 4;
   localparam logic [31:0] FLAG = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_valid = 1'b0;
   logic        reg_write = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [30:0] evt_pulse = '0;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   nic_irq_ctrl #(
      .DATA_W      (DW),
      .IV_W        (8),
      .UNIT_CYCLES (UNIT)
   ) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_valid (reg_valid),
      .reg_write (reg_write),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_pulse (evt_pulse),
      .irq_o     (irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_valid = 1'b0;
   endtask

   task automatic pulse(input logic [30:0] bits);
      @(negedge clk);
      evt_pulse = bits;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] d;
      logic [31:0] acc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq", {31'b0, irq_o}, 32'h0);
      rd(ADR_MSET, d);  chk("R1 mask", d, 32'h0);
      rd(ADR_AMASK, d); chk("R1 pattern", d, 32'h0);
      rd(ADR_THR, d);   chk("R1 interval", d, 32'h0);
      rd(ADR_CTL, d);   chk("R1 control", d, 32'h0);
      rd(ADR_CAUSE, d); chk("R1 cause", d, 32'h0);

      // R12 readback
      wr(ADR_AMASK, 32'h7ABC_D0F0); rd(ADR_AMASK, d); chk("R12 pattern", d, 32'h7ABC_D0F0);
      wr(ADR_THR, 32'h0000_1205);   rd(ADR_THR, d);   chk("R12 interval", d, 32'h05);
      wr(ADR_CTL, 32'h1);           rd(ADR_CTL, d);   chk("R12 control", d, 32'h1);
      wr(ADR_AMASK, 32'h0); wr(ADR_THR, 32'h0); wr(ADR_CTL, 32'h0);

      // R6 mask set/clear sweep
      acc = 32'h0;
      for (int i = 0; i < 31; i++) begin
         wr(ADR_MSET, 32'h1 << i);
         acc |= 32'h1 << i;
         rd(ADR_MCLR, d); chk("R6 mask set", d, acc);
      end
      for (int i = 0; i < 31; i++) begin
         wr(ADR_MCLR, 32'h1 << i);
         acc &= ~(32'h1 << i);
         rd(ADR_MSET, d); chk("R6 mask clear", d, acc);
      end

      // R2 per-bit event sweep, zero interval
      for (int i = 0; i < 31; i++) begin
         wr(ADR_MSET, 32'h1 << i);
         pulse(31'(32'h1 << i));
         chk("R2 irq up", {31'b0, irq_o}, 32'h1);
         rd(ADR_CAUSE, d); chk("R2 cause", d, FLAG | (32'h1 << i));
         chk("R3 irq after read", {31'b0, irq_o}, 32'h0);
         wr(ADR_MCLR, 32'h1 << i);
      end

      // R3 conditional clear, R11 unmask with zero interval
      wr(ADR_MSET, 32'h4);
      pulse(31'h2);
      chk("R11 masked stays low", {31'b0, irq_o}, 32'h0);
      rd(ADR_CAUSE, d); chk("R3 kept 1", d, 32'h2);
      rd(ADR_CAUSE, d); chk("R3 kept 2", d, 32'h2);
      wr(ADR_MSET, 32'h2);
      chk("R11 unmask fires", {31'b0, irq_o}, 32'h1);
      rd(ADR_CAUSE, d); chk("R3 flagged read", d, FLAG | 32'h2);
      rd(ADR_CAUSE, d); chk("R3 cleared", d, 32'h0);
      wr(ADR_MCLR, 32'h7FFF_FFFF);
      pulse(31'h8);
      rd(ADR_CAUSE, d); chk("R3 zero mask read", d, 32'h8);
      rd(ADR_CAUSE, d); chk("R3 zero mask cleared", d, 32'h0);

      // R5 write-one-to-clear
      wr(ADR_MSET, 32'h3);
      pulse(31'h3);
      chk("R5 irq up", {31'b0, irq_o}, 32'h1);
      wr(ADR_CAUSE, 32'h1);
      chk("R5 partial keeps irq", {31'b0, irq_o}, 32'h1);
      wr(ADR_CAUSE, 32'h2);
      chk("R5 cleared drops irq", {31'b0, irq_o}, 32'h0);
      rd(ADR_CAUSE, d); chk("R5 causes", d, 32'h0);
      wr(ADR_CTL, 32'h1); wr(ADR_AMASK, 32'h3);
      wr(ADR_CAUSE, 32'h0);
      rd(ADR_MSET, d); chk("R5 automask on write", d, 32'h0);

      // R4 auto-mask on read
      wr(ADR_MSET, 32'h7);
      pulse(31'h4);
      chk("R4 irq up", {31'b0, irq_o}, 32'h1);
      rd(ADR_CAUSE, d); chk("R4 cause", d, FLAG | 32'h4);
      rd(ADR_MSET, d);  chk("R4 masked by pattern", d, 32'h4);
      wr(ADR_MSET, 32'h3);
      rd(ADR_CAUSE, d); chk("R4 unflagged cause", d, 32'h0);
      rd(ADR_MSET, d);  chk("R4 no automask without flag", d, 32'h7);
      wr(ADR_CTL, 32'h0); wr(ADR_MCLR, 32'h7FFF_FFFF); wr(ADR_AMASK, 32'h0);

      // R9 throttle, interval 2 -> 8 cycles, mid-run event does not restart
      wr(ADR_THR, 32'h2);
      wr(ADR_MSET, 32'h11);
      pulse(31'h1);
      chk("R9 deferred", {31'b0, irq_o}, 32'h0);
      pulse(31'h10);
      idle(2 * UNIT - 1 - 2);
      chk("R9 low before interval", {31'b0, irq_o}, 32'h0);
      idle(1);
      chk("R9 high at interval", {31'b0, irq_o}, 32'h1);
      rd(ADR_CAUSE, d); chk("R9 cause", d, FLAG | 32'h11);
      wr(ADR_MCLR, 32'h7FFF_FFFF);

      // R8 repost rules, R11 unmask with throttle
      pulse(31'h41);
      wr(ADR_MSET, 32'h1);
      pulse(31'h1);
      chk("R8 repost no effect", {31'b0, irq_o}, 32'h0);
      pulse(31'h40);
      chk("R8 immediate already set", {31'b0, irq_o}, 32'h1);
      rd(ADR_CAUSE, d); chk("R8 cause", d, FLAG | 32'h41);
      wr(ADR_MSET, 32'h40);
      pulse(31'h1);
      chk("R8 timer pending", {31'b0, irq_o}, 32'h0);
      pulse(31'h40);
      chk("R8 immediate override", {31'b0, irq_o}, 32'h1);
      rd(ADR_CAUSE, d); chk("R8 cause 2", d, FLAG | 32'h41);
      wr(ADR_MCLR, 32'h7FFF_FFFF);

      // R10 cancel and restart
      wr(ADR_MSET, 32'h1);
      pulse(31'h1);
      wr(ADR_MCLR, 32'h1);
      idle(10);
      chk("R10 cancelled stays low", {31'b0, irq_o}, 32'h0);
      wr(ADR_MSET, 32'h1);
      idle(2 * UNIT - 1);
      chk("R11 low before full interval", {31'b0, irq_o}, 32'h0);
      idle(1);
      chk("R11 fires after unmask", {31'b0, irq_o}, 32'h1);
      wr(ADR_MCLR, 32'h1);
      chk("R10 unmask drops line", {31'b0, irq_o}, 32'h0);
      rd(ADR_CAUSE, d); chk("R10 flag cleared", d, 32'h1);

      // R7 cause injection
      wr(ADR_THR, 32'h0);
      wr(ADR_MSET, 32'h200);
      wr(ADR_CSET, 32'h200);
      chk("R7 inject raises", {31'b0, irq_o}, 32'h1);
      rd(ADR_CAUSE, d); chk("R7 cause", d, FLAG | 32'h200);
      wr(ADR_THR, 32'h2);
      wr(ADR_MSET, 32'h40);
      wr(ADR_CSET, 32'h40);
      chk("R7 inject immediate", {31'b0, irq_o}, 32'h1);
      rd(ADR_CAUSE, d); chk("R7 cause 2", d, FLAG | 32'h40);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule